// File: doc/BRIEF.md
# Maskable Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines from peripherals and turns them into one registered request to the processor. Each line passes through a two-stage synchronizer and is then visible, unmasked, in a read-only source register. A mask register decides which of the synchronized lines may raise the request. A mask bit of one blocks its line. The lines that are active and not blocked appear in a pending register, and the request output is high while any of them is set.

Software never needs a read-modify-write on the mask. Besides the directly writable mask register there are two alias registers. Writing ones to the first sets those mask bits. Writing ones to the second clears them. Bits written as zero are untouched in both cases. A handler can therefore block the line it is servicing with a single write, and the request drops one cycle later.

The register port is a plain synchronous bus. It has one address, a write enable with write data, and a read enable with registered read data. It has no handshake and no back-pressure: every access is accepted in the cycle it is presented, and at most one write happens per cycle. Only a fixed set of 15 bit positions is implemented: 3, 10 to 13, 17 to 19 and 22 to 28. Every other position reads as zero in all registers. Byte offsets are: source 0x00, mask 0x04, mask-set alias 0x08, mask-clear alias 0x0c, pending 0x10.

Top module: `irq_mask_hub`

## Requirements
- R1: After reset every implemented mask bit is one and every unimplemented mask bit is zero. The request output is low and the read data is zero.
- R2: A read of offset 0x00 returns the state of the interrupt lines as sampled two clock edges earlier, whatever the mask holds. A line that is taken low disappears from this register.
- R3: The source and pending registers read as zero at every unimplemented bit position (bits 0–2, 4–9, 14–16, 20, 21, 29–31), whatever the lines or the mask hold.
- R4: A write to offset 0x08 sets each mask bit whose write-data bit is one and leaves every other mask bit unchanged.
- R5: A write to offset 0x0c clears each mask bit whose write-data bit is one and leaves every other mask bit unchanged.
- R6: A write to offset 0x04 loads the mask with the write data at the implemented positions. Unimplemented positions stay zero.
- R7: A read of offset 0x10 returns the source bits that are one where the mask bit is zero (source AND NOT mask).
- R8: The request output is registered. It equals the OR of the pending bits one cycle earlier. A write that masks the only pending line drops the request at the second clock edge after the write is presented.
- R9: Reads of offsets 0x08 and 0x0c return the current mask. Reads of any unmapped address return zero. Writes to unmapped addresses change no register.
- R10: Read data is updated on the clock edge that sees read enable high and holds its value while read enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | DW (32) | Level-sensitive interrupt lines from peripherals |
| bus_addr | input | AW (5) | Register byte address |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wr_data | input | DW (32) | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | DW (32) | Registered read data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Line changes reach the source and pending registers after two edges. They reach the request output after three. A mask write is visible in a read presented on the next cycle, and it reaches the request output after two edges. Read data appears one edge after the strobe. The bench drives on the falling edge and waits the stated number of edges before a read or a direct check of the request output. In particular, it samples the request one cycle after a masking write, expects the old value there, and expects the new value one cycle later. Every read pushes its expected value into a scoreboard queue. A monitor pops that value on the falling edge after the read edge and compares it with the read data.

// File: rtl/irqh_pkg.sv
package irqh_pkg;
  localparam int unsigned IRQH_DW   = 32;
  // implemented lines: 28..22, 19..17, 13..10, 3
  localparam logic [31:0] IRQH_LIVE = 32'h1FCE_3C08;

  localparam int unsigned OFF_SRC  = 'h00;
  localparam int unsigned OFF_MASK = 'h04;
  localparam int unsigned OFF_MSET = 'h08;
  localparam int unsigned OFF_MCLR = 'h0c;
  localparam int unsigned OFF_PEND = 'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SRC,
    SEL_MASK,
    SEL_MSET,
    SEL_MCLR,
    SEL_PEND
  } reg_sel_e;

  function automatic reg_sel_e addr_decode(input int unsigned a);
    case (a)
      OFF_SRC:  return SEL_SRC;
      OFF_MASK: return SEL_MASK;
      OFF_MSET: return SEL_MSET;
      OFF_MCLR: return SEL_MCLR;
      OFF_PEND: return SEL_PEND;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irqh_sync.sv
module irqh_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irqh_mask.sv
module irqh_mask
  import irqh_pkg::*;
#(
  parameter int           W    = 32,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] mask_q
);
  logic [W-1:0] set_v, clr_v, mask_d;
  logic         load;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    load  = 1'b0;
    if (wr_en) begin
      case (sel)
        SEL_MASK: load  = 1'b1;
        SEL_MSET: set_v = wr_data & LIVE;
        SEL_MCLR: clr_v = wr_data & LIVE;
        default: ;
      endcase
    end
    // clear is applied last, so it wins over a set of the same bit
    mask_d = load ? (wr_data & LIVE) : ((mask_q | set_v) & ~clr_v);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= LIVE;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/irqh_pend.sv
module irqh_pend #(
  parameter int           W    = 32,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic [W-1:0] mask,
  output logic [W-1:0] pend,
  output logic         irq_q
);
  assign pend = src & ~mask & LIVE;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pend;
  end
endmodule

// File: rtl/irqh_rdmux.sv
module irqh_rdmux
  import irqh_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_en,
  input  reg_sel_e     sel,
  input  logic [W-1:0] src,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] pend,
  output logic [W-1:0] rd_q
);
  logic [W-1:0] rd_d;

  always_comb begin
    case (sel)
      SEL_SRC:                     rd_d = src;
      SEL_MASK, SEL_MSET, SEL_MCLR: rd_d = mask;
      SEL_PEND:                    rd_d = pend;
      default:                     rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end
endmodule

// File: rtl/irq_mask_hub.sv
module irq_mask_hub
  import irqh_pkg::*;
#(
  parameter int            DW        = IRQH_DW,
  parameter int            AW        = 5,
  parameter int            SYNC_STG  = 2,
  parameter logic [DW-1:0] LIVE_MASK = IRQH_LIVE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] irq_lines,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr_en,
  input  logic [DW-1:0] bus_wr_data,
  input  logic          bus_rd_en,
  output logic [DW-1:0] bus_rd_data,
  output logic          irq_out
);
  reg_sel_e      sel;
  logic [DW-1:0] src_sync, src_live, mask_q, pend_w;

  assign sel      = addr_decode(int'(bus_addr));
  assign src_live = src_sync & LIVE_MASK;

  irqh_sync #(.W(DW), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_lines), .q(src_sync)
  );

  irqh_mask #(.W(DW), .LIVE(LIVE_MASK)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .sel(sel),
    .wr_data(bus_wr_data), .mask_q(mask_q)
  );

  irqh_pend #(.W(DW), .LIVE(LIVE_MASK)) u_pend (
    .clk(clk), .rst_n(rst_n), .src(src_live), .mask(mask_q),
    .pend(pend_w), .irq_q(irq_out)
  );

  irqh_rdmux #(.W(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_rd_en), .sel(sel),
    .src(src_live), .mask(mask_q), .pend(pend_w), .rd_q(bus_rd_data)
  );
endmodule

// File: rtl/irq_mask_hub_chk.sv
module irq_mask_hub_chk
  import irqh_pkg::*;
#(
  parameter int            DW   = 32,
  parameter int            AW   = 5,
  parameter logic [DW-1:0] LIVE = '1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr_en,
  input logic [DW-1:0] bus_wr_data,
  input logic          bus_rd_en,
  input logic [DW-1:0] bus_rd_data,
  input logic [DW-1:0] mask_q,
  input logic [DW-1:0] pend_w,
  input logic          irq_out
);
  logic at_set, at_clr, at_mask, at_map, at_view;
  assign at_set  = int'(bus_addr) == OFF_MSET;
  assign at_clr  = int'(bus_addr) == OFF_MCLR;
  assign at_mask = int'(bus_addr) == OFF_MASK;
  assign at_map  = at_set || at_clr || at_mask;
  assign at_view = int'(bus_addr) == OFF_SRC || int'(bus_addr) == OFF_PEND;

  // R4
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en && at_set |=> mask_q == ($past(mask_q) | ($past(bus_wr_data) & LIVE)));

  // R5
  clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en && at_clr |=> mask_q == ($past(mask_q) & ~$past(bus_wr_data)));

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en && at_mask |=> mask_q == ($past(bus_wr_data) & LIVE));

  // R9
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && at_map) |=> $stable(mask_q));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_out == (|$past(pend_w)));

  // R3
  dead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd_en) && $past(at_view) |-> (bus_rd_data & ~LIVE) == '0);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> $stable(bus_rd_data));
endmodule

bind irq_mask_hub irq_mask_hub_chk #(.DW(DW), .AW(AW), .LIVE(LIVE_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
  .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
  .mask_q(mask_q), .pend_w(pend_w), .irq_out(irq_out)
);

// File: tb/tb_irq_mask_hub.sv
`timescale 1ns/1ps
module tb_irq_mask_hub;
  localparam logic [31:0] LIVE = 32'h1FCE_3C08;
  localparam logic [4:0] A_SRC = 5'h00, A_MASK = 5'h04, A_SET = 5'h08,
                         A_CLR = 5'h0c, A_PEND = 5'h10, A_BAD = 5'h14;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] irq_lines = '0, bus_wr_data = '0, bus_rd_data;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0, irq_out, rd_seen = 1'b0;
  int          checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  irq_mask_hub dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
    .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en),
    .bus_rd_data(bus_rd_data), .irq_out(irq_out)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: read data is due one edge after the strobe
  always @(posedge clk) rd_seen <= bus_rd_en && rst_n;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check(bus_rd_data, 32'hx, "scoreboard underrun");
      end else begin
        check(bus_rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    idle(3);
    check({31'd0, irq_out}, 32'd0, "R1 irq low in reset");
    check(bus_rd_data, 32'd0, "R1 read data zero in reset");
    rst_n = 1'b1;
    rd(A_MASK, LIVE, "R1 mask reset value");
    rd(A_SRC, 32'd0, "R2 source idle");

    irq_lines = 32'hFFFF_FFFF;
    idle(3);
    rd(A_SRC, LIVE, "R2 R3 source all lines");
    rd(A_PEND, 32'd0, "R7 all masked pending");
    check({31'd0, irq_out}, 32'd0, "R1 irq low while masked");

    wr(A_CLR, 32'h0000_0008);
    rd(A_MASK, LIVE & ~32'h8, "R5 clear alias one bit");
    rd(A_PEND, 32'h0000_0008, "R7 pending one line");
    check({31'd0, irq_out}, 32'd1, "R8 irq high");

    wr(A_SET, 32'h0000_0008);
    check({31'd0, irq_out}, 32'd1, "R8 irq one cycle after mask");
    @(negedge clk);
    check({31'd0, irq_out}, 32'd0, "R8 irq two cycles after mask");

    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, LIVE, "R6 direct load all ones");
    wr(A_MASK, 32'd0);
    rd(A_MASK, 32'd0, "R6 direct load zero");
    rd(A_PEND, LIVE, "R3 R7 pending all open");
    check({31'd0, irq_out}, 32'd1, "R8 irq with all open");

    wr(A_SET, 32'h1000_0000);
    rd(A_MASK, 32'h1000_0000, "R4 set alias one bit");
    rd(A_SET, 32'h1000_0000, "R9 set alias reads mask");
    rd(A_CLR, 32'h1000_0000, "R9 clear alias reads mask");

    irq_lines = 32'h1200_0409;
    idle(3);
    rd(A_SRC, 32'h1200_0408, "R2 R3 source pattern");
    rd(A_PEND, 32'h0200_0408, "R7 pending pattern");

    wr(A_BAD, 32'hFFFF_FFFF);
    rd(A_MASK, 32'h1000_0000, "R9 unmapped write ignored");
    rd(A_BAD, 32'd0, "R9 unmapped read zero");

    wr(A_CLR, 32'h1000_0000);
    rd(A_PEND, 32'h1200_0408, "R5 pending after clear");
    held = 32'h1200_0408;
    idle(4);
    check(bus_rd_data, held, "R10 read data holds");

    irq_lines = 32'd0;
    idle(4);
    rd(A_SRC, 32'd0, "R2 lines released");
    rd(A_PEND, 32'd0, "R7 pending released");
    check({31'd0, irq_out}, 32'd0, "R8 irq released");

    idle(2);
    check(exp_q.size(), 32'd0, "scoreboard drained");
    finish_run();
  end
endmodule